// File: doc/BRIEF.md
# Processor interrupt input conditioner

This block takes the raw interrupt and control pins that arrive at a processor core and turns them into a pending-interrupt vector, a halt control and a single summary request. Each pin is first brought into the core clock domain through two flops. The block then compares each synchronized level with the level it last stored for that pin, and acts only when the two differ. What it does on a change depends on the pin. External and system management interrupts follow the pin level. Machine check latches on a falling edge. Checkstop drives the halt output. Soft reset follows its level into a reset pending bit. Hard reset is accepted but leaves the vector alone.

The core acknowledges a pending bit by pulsing its clear input. The summary request stays high while any pending bit is set, and drops only once the vector is empty. Input positions above the six defined pins are synchronized but never acted on.

Pin positions on `pin_i`: 0 external interrupt, 1 system management interrupt, 2 machine check, 3 checkstop, 4 hard reset, 5 soft reset, 6 and up undefined. Pending positions on `pend_o` and `ack_i`: 0 external, 1 system management, 2 machine check, 3 soft reset.

Top module: `irq_cond`

## Requirements
- R1: A change on any pin reaches the outputs on the third rising clock edge after it is first sampled. Two of those edges are synchronizer stages and one is the update edge. Before that edge the outputs do not reflect the change.
- R2: On a change of pin 0 or pin 1, `pend_o[0]` or `pend_o[1]` respectively takes the new level. While the pin holds its level, the bit is not set again after an acknowledge.
- R3: A 1-to-0 transition of pin 2 sets `pend_o[2]`. A 0-to-1 transition of pin 2 neither sets nor clears it, and the bit holds until acknowledged.
- R4: On a change of pin 3, `halt_o` takes the new level: 1 means halted and 0 means resumed.
- R5: On a change of pin 5, `pend_o[3]` takes the new level.
- R6: Changes on pin 4 alter neither `pend_o` nor `halt_o`.
- R7: `irq_o` is 1 exactly when at least one bit of `pend_o` is 1.
- R8: Pins at positions 6 and above affect neither `pend_o` nor `halt_o`.
- R9: `ack_i[k]` clears `pend_o[k]` on the next edge. For the machine check bit, an acknowledge wins over a falling edge arriving in the same cycle. For the level-following bits 0, 1 and 3, a pin change in the same cycle wins over the acknowledge.
- R10: While `rst_n` is 0, `pend_o`, `halt_o` and `irq_o` are 0, and all stored levels and synchronizer stages are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | IN_W | Raw pin levels: 0 ext, 1 smi, 2 mck, 3 checkstop, 4 hard reset, 5 soft reset, 6+ undefined |
| ack_i | input | 4 | Per-bit clear of the pending vector |
| pend_o | output | 4 | Pending vector: 0 ext, 1 smi, 2 mck, 3 soft reset |
| halt_o | output | 1 | Halt request to the core |
| irq_o | output | 1 | Summary request, OR of the pending vector |

## Verification
The acknowledge of a pending bit and a new event on that bit's pin can land on the same update edge, and the winner differs by bit type. The bench provokes this by counting the synchronizer delay. It lowers the machine check pin, and asserts `ack_i[2]` exactly in the cycle when the falling edge reaches the update stage; the bit must then read 0. It repeats this with a rising external interrupt against `ack_i[0]`, where the bit must read 1. Random pins and sparse random acknowledges then hit the same collision many more times, and every cycle is judged against a bench model of the per-bit rules.

// File: rtl/irq_cond.sv
`timescale 1ns/1ps
module irq_cond #(
  parameter int IN_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] pin_i,
  input  logic [3:0]      ack_i,
  output logic [3:0]      pend_o,
  output logic            halt_o,
  output logic            irq_o
);
  localparam int NDEF = 6;
  localparam logic [IN_W-1:0] DEF_MASK = {{(IN_W-NDEF){1'b0}}, {NDEF{1'b1}}};

  logic [IN_W-1:0] s1, s2, lvl_q, chg;
  logic [3:0]      pend_d;
  logic            mck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= pin_i;
      s2 <= s1;
    end
  end

  assign chg      = (s2 ^ lvl_q) & DEF_MASK;
  assign mck_fall = chg[2] & ~s2[2];

  assign pend_d[0] = chg[0] ? s2[0] : (pend_o[0] & ~ack_i[0]);
  assign pend_d[1] = chg[1] ? s2[1] : (pend_o[1] & ~ack_i[1]);
  assign pend_d[2] = ~ack_i[2] & (pend_o[2] | mck_fall);
  assign pend_d[3] = chg[5] ? s2[5] : (pend_o[3] & ~ack_i[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      pend_o <= '0;
      halt_o <= 1'b0;
    end else begin
      lvl_q  <= lvl_q ^ chg;
      pend_o <= pend_d;
      if (chg[3]) halt_o <= s2[3];
    end
  end

  assign irq_o = |pend_o;
endmodule

// File: rtl/irq_cond_chk.sv
`timescale 1ns/1ps
module irq_cond_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_ext,
  input logic       pin_smi,
  input logic       pin_ckstp,
  input logic       pin_srst,
  input logic       ack_mck,
  input logic [3:0] pend,
  input logic       halt
);
  AST_EXT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> $past(pin_ext, 3)); // R2
  AST_SMI_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[1]) |-> $past(pin_smi, 3)); // R2
  AST_SRST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[3]) |-> $past(pin_srst, 3)); // R5
  AST_MCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[2] && !ack_mck) |=> pend[2]); // R3
  AST_MCK_ACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_mck |=> !pend[2]); // R9
  AST_HALT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(halt) |-> (halt == $past(pin_ckstp, 3))); // R4
endmodule

bind irq_cond irq_cond_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .pin_ext(pin_i[0]), .pin_smi(pin_i[1]), .pin_ckstp(pin_i[3]), .pin_srst(pin_i[5]),
  .ack_mck(ack_i[2]), .pend(pend_o), .halt(halt_o)
);

// File: tb/sim_irq_cond.sv
`timescale 1ns/1ps
module sim_irq_cond;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = '0;
  logic [3:0] ack = '0;
  logic [3:0] pend;
  logic       halt, irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [7:0] m_s1, m_s2, m_prev;
  logic [3:0] m_pend;
  logic       m_halt;

  always #2.5 clk = ~clk;

  irq_cond #(.IN_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .ack_i(ack),
    .pend_o(pend), .halt_o(halt), .irq_o(irq)
  );

  function automatic logic [3:0] f_pend(input logic [3:0] p, input logic [7:0] o,
                                        input logic [7:0] n, input logic [3:0] a);
    logic [3:0] r;
    r[0] = (o[0] != n[0]) ? n[0] : (p[0] & ~a[0]);
    r[1] = (o[1] != n[1]) ? n[1] : (p[1] & ~a[1]);
    r[2] = ~a[2] & (p[2] | (o[2] & ~n[2]));
    r[3] = (o[5] != n[5]) ? n[5] : (p[3] & ~a[3]);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_halt = 1'b0;
    end else begin
      m_pend = f_pend(m_pend, m_prev, m_s2, ack);
      if (m_prev[3] != m_s2[3]) m_halt = m_s2[3];
      m_prev[5:0] = m_s2[5:0];
      m_s2 = m_s1;
      m_s1 = pin;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    step();
    chk("R2 ext/smi", {6'd0, pend[1:0]}, {6'd0, m_pend[1:0]});
    chk("R3 mck", {7'd0, pend[2]}, {7'd0, m_pend[2]});
    chk("R5 srst", {7'd0, pend[3]}, {7'd0, m_pend[3]});
    chk("R4 halt", {7'd0, halt}, {7'd0, m_halt});
    chk("R7 irq", {7'd0, irq}, {7'd0, |m_pend});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    ticks(3);
    chk("R10 reset pend", {4'd0, pend}, 8'h00);
    chk("R10 reset halt/irq", {6'd0, halt, irq}, 8'h00);
    rst_n = 1'b1;
    ticks(2);

    pin[0] = 1'b1;
    ticks(2);
    chk("R1 before third edge", {7'd0, pend[0]}, 8'h00);
    tick();
    chk("R1 third edge", {7'd0, pend[0]}, 8'h01);
    chk("R7 set", {7'd0, irq}, 8'h01);

    ack[0] = 1'b1; tick(); ack = '0;
    ticks(4);
    chk("R2 held level no reset", {7'd0, pend[0]}, 8'h00);
    chk("R7 empty", {7'd0, irq}, 8'h00);

    pin[2] = 1'b1; ticks(4);
    chk("R3 rise no set", {7'd0, pend[2]}, 8'h00);
    pin[2] = 1'b0; ticks(4);
    chk("R3 fall sets", {7'd0, pend[2]}, 8'h01);
    pin[2] = 1'b1; ticks(4);
    chk("R3 rise no clear", {7'd0, pend[2]}, 8'h01);

    pin[2] = 1'b0; ticks(2);
    ack[2] = 1'b1; tick(); ack = '0;
    chk("R9 ack beats mck edge", {7'd0, pend[2]}, 8'h00);
    ticks(3);
    chk("R9 mck stays clear", {7'd0, pend[2]}, 8'h00);

    pin[0] = 1'b0; ticks(4);
    pin[0] = 1'b1; ticks(2);
    ack[0] = 1'b1; tick(); ack = '0;
    chk("R9 level change beats ack", {7'd0, pend[0]}, 8'h01);

    pin[3] = 1'b1; ticks(4);
    chk("R4 halt on", {7'd0, halt}, 8'h01);
    pin[3] = 1'b0; ticks(4);
    chk("R4 halt off", {7'd0, halt}, 8'h00);

    pin[5] = 1'b1; ticks(4);
    chk("R5 srst set", {7'd0, pend[3]}, 8'h01);
    pin[5] = 1'b0; ticks(4);
    chk("R5 srst clear", {7'd0, pend[3]}, 8'h00);

    ack = 4'hF; tick(); ack = '0;
    pin[4] = 1'b1; ticks(4);
    pin[4] = 1'b0; ticks(4);
    chk("R6 hreset pend", {4'd0, pend}, 8'h00);
    chk("R6 hreset halt", {7'd0, halt}, 8'h00);

    pin[7:6] = 2'b11; ticks(4);
    pin[7:6] = 2'b01; ticks(4);
    chk("R8 undefined pend", {4'd0, pend}, 8'h00);
    chk("R8 undefined halt/irq", {6'd0, halt, irq}, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] flip;
      flip = 8'($urandom) & 8'($urandom) & 8'($urandom);
      pin  = pin ^ flip;
      ack  = 4'($urandom) & 4'($urandom) & 4'($urandom);
      tick();
    end
    ack = '0;
    ticks(4);

    rst_n = 1'b0;
    ticks(2);
    chk("R10 mid-run reset", {2'd0, halt, irq, pend}, 8'h00);
    finish_run();
  end
endmodule